// File: doc/BRIEF.md
# Half-Bridge Gate-Drive Sequencer

This block turns a three-level PWM command into the two gate enables of a synchronous buck half-bridge. An external window comparator digitises the PWM pin into a 2-bit code. The block then qualifies a mid-window level with a hold-off timer. It turns one gate on only after the other gate's feedback reports it off and a non-overlap delay has then run out. It drops both gates when the supply lockout, the disable comparator or the die-temperature shutdown requests it.

The block has no data stream, so there is no valid/ready interface. Every pin is a plain control or status level that is sampled on each rising clock edge. The gate feedback inputs come from the gate monitors: each reads 1 when the matching power switch is fully off. The hold-off time, the non-overlap delay and the two thermal thresholds are parameters. For example, 25 cycles at 100 MHz gives the 250 ns hold-off.

Top module: `hbd_gate_sequencer`

## Requirements
- R1: Reset drives both gates low and clears every timer. With the PWM code at low during reset, the low-side gate turns on DEAD_CYC+2 cycles after reset is released.
- R2: The high-side and low-side gates are never high in the same cycle.
- R3: PWM code 2'b01 (high) makes the high side the target and code 2'b00 (low) makes the low side the target. The conducting gate drops 2 cycles after the code changes. With immediate feedback, the new gate rises DEAD_CYC+2 cycles after the code changes.
- R4: The non-overlap counter advances only while the opposite gate is commanded off and its feedback reports it off. While that feedback stays low, the target gate stays off. After the feedback goes high, the target gate rises DEAD_CYC cycles later.
- R5: A mid-window code (2'b10 or 2'b11) held for HOLD_CYC consecutive cycles drops both gates one cycle later, and they stay low while the code remains mid-window.
- R6: A mid-window excursion of HOLD_CYC-1 cycles or fewer leaves both gates unchanged.
- R7: Leaving a qualified tri-state adds no further hold-off. Code low turns on the low side and code high turns on the high side, each DEAD_CYC+2 cycles after the code changes.
- R8: The gates are enabled only when enable_code is 2'b01 (driven high). Code 2'b00 (driven low) and codes 2'b1x (undriven) force both gates low 2 cycles later.
- R9: While uvlo_active is 1, both gates are forced low 2 cycles later and PWM changes have no effect. When uvlo_active clears, the gates resequence as in R7.
- R10: Thermal shutdown sets when die_temp exceeds TRIP_HI (180) and clears only when die_temp falls below TRIP_LO (155). While it is set, both gates are low, starting 2 cycles after the trip.
- R11: If the target changes while a non-overlap delay is pending, the delay restarts from zero toward the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_code | input | 2 | Digitised PWM: 00 low, 01 high, 1x mid-window |
| enable_code | input | 2 | Digitised disable pin: 01 enabled, 00 low, 1x undriven |
| uvlo_active | input | 1 | Supply lockout is active |
| die_temp | input | TEMP_W | Die temperature in °C, unsigned |
| hs_off_fb | input | 1 | High-side switch reported off |
| ls_off_fb | input | 1 | Low-side switch reported off |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
Every result has a fixed delay from its stimulus:
- An input that forces the gates off shows at the gates 2 cycles later: one register captures the request and the sequencer acts on the next edge.
- A new gate rises DEAD_CYC+2 cycles after a PWM change: one cycle to register the command, one to see the target change, then DEAD_CYC counting cycles.
- A held mid-window code drops the gates HOLD_CYC+1 cycles after it starts.

The driver task records each expected gate pair together with the exact cycle in which it is due. The monitor compares it on the falling edge of that cycle. The cycle before each transition is also checked, so an early or late edge is caught as a mismatch.

// File: rtl/hbd_pkg.sv
`timescale 1ns/1ps
package hbd_pkg;
  // Which gate the sequencer is steering toward.
  typedef enum logic [1:0] {
    TGT_OFF  = 2'd0,
    TGT_LOW  = 2'd1,
    TGT_HIGH = 2'd2
  } tgt_e;

  // Digitised PWM window codes; bit 1 set means mid-window.
  localparam logic [1:0] PWM_LOW  = 2'b00;
  localparam logic [1:0] PWM_HIGH = 2'b01;

  // Digitised disable-pin code that alone means "driven high, enabled".
  localparam logic [1:0] EN_DRIVEN_HIGH = 2'b01;
endpackage

// File: rtl/hbd_tristate_qual.sv
`timescale 1ns/1ps
module hbd_tristate_qual
  import hbd_pkg::*;
#(
  parameter int HOLD_CYC = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_code,
  output tgt_e       cmd
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic          is_mid;
  logic [CW-1:0] mid_cnt_q;
  tgt_e          cmd_q;

  assign is_mid = pwm_code[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_cnt_q <= '0;
      cmd_q     <= TGT_OFF;
    end else if (!is_mid) begin
      mid_cnt_q <= '0;
      cmd_q     <= (pwm_code == PWM_HIGH) ? TGT_HIGH : TGT_LOW;
    end else if (mid_cnt_q == LAST) begin
      cmd_q     <= TGT_OFF;
    end else begin
      mid_cnt_q <= mid_cnt_q + 1'b1;
    end
  end

  assign cmd = cmd_q;

  // Tri-state only qualifies after the full hold-off of mid-window samples.
  assert_off_after_holdoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == TGT_OFF && $past(cmd_q) != TGT_OFF) |-> ($past(is_mid) && $past(mid_cnt_q) == LAST));

  assert_holdoff_cnt_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mid_cnt_q <= LAST);
endmodule

// File: rtl/hbd_thermal_latch.sv
`timescale 1ns/1ps
module hbd_thermal_latch #(
  parameter int TEMP_W  = 8,
  parameter int TRIP_HI = 180,
  parameter int TRIP_LO = 155
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] die_temp,
  output logic              shutdown
);
  localparam logic [TEMP_W-1:0] HI_T = TEMP_W'(TRIP_HI);
  localparam logic [TEMP_W-1:0] LO_T = TEMP_W'(TRIP_LO);

  logic sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sd_q <= 1'b0;
    else if (die_temp > HI_T) sd_q <= 1'b1;
    else if (die_temp < LO_T) sd_q <= 1'b0;
  end

  assign shutdown = sd_q;

  assert_trip_above_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_q) |-> ($past(die_temp) > HI_T));

  assert_release_below_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_q) |-> ($past(die_temp) < LO_T));
endmodule

// File: rtl/hbd_deadtime_seq.sv
`timescale 1ns/1ps
module hbd_deadtime_seq
  import hbd_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  tgt_e tgt,
  input  logic hs_off_fb,
  input  logic ls_off_fb,
  output logic hs_gate,
  output logic ls_gate
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);

  // Side index: 0 = low side, 1 = high side.
  logic [1:0]    gate_q, gate_d, off_fb, want;
  logic [CW-1:0] cnt_q, cnt_d;
  tgt_e          last_q;
  logic          opp_off, qual, fire;

  assign off_fb = {hs_off_fb, ls_off_fb};

  // Counting requires a stable target, both gates commanded off,
  // and the opposite gate's monitor confirming it is off.
  assign opp_off = want[1] ? off_fb[0] : off_fb[1];
  assign qual    = (tgt == last_q) && (want != 2'b00) && (gate_q == 2'b00) && opp_off;
  assign fire    = qual && (cnt_q == LAST);
  assign cnt_d   = (!qual || fire) ? '0 : cnt_q + 1'b1;

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam tgt_e SIDE_TGT = (s == 1) ? TGT_HIGH : TGT_LOW;
    assign want[s]   = (tgt == SIDE_TGT);
    assign gate_d[s] = want[s] & (gate_q[s] | fire);

    // A gate may rise only after the other side was seen off.
    assert_waits_opposite_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_q[s]) |-> ($past(off_fb[1-s]) && !$past(gate_q[1-s])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 2'b00;
      cnt_q  <= '0;
      last_q <= TGT_OFF;
    end else begin
      gate_q <= gate_d;
      cnt_q  <= cnt_d;
      last_q <= tgt;
    end
  end

  assign hs_gate = gate_q[1];
  assign ls_gate = gate_q[0];

  assert_no_shoot_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_q[0] && gate_q[1]));

  assert_target_change_restarts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt != last_q) |=> (cnt_q == '0));
endmodule

// File: rtl/hbd_gate_sequencer.sv
`timescale 1ns/1ps
module hbd_gate_sequencer
  import hbd_pkg::*;
#(
  parameter int HOLD_CYC = 25,
  parameter int DEAD_CYC = 4,
  parameter int TEMP_W   = 8,
  parameter int TRIP_HI  = 180,
  parameter int TRIP_LO  = 155
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pwm_code,
  input  logic [1:0]        enable_code,
  input  logic              uvlo_active,
  input  logic [TEMP_W-1:0] die_temp,
  input  logic              hs_off_fb,
  input  logic              ls_off_fb,
  output logic              hs_gate,
  output logic              ls_gate
);
  tgt_e cmd, tgt;
  logic thermal_sd, force_q;

  hbd_tristate_qual #(.HOLD_CYC(HOLD_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .pwm_code(pwm_code), .cmd(cmd)
  );

  hbd_thermal_latch #(.TEMP_W(TEMP_W), .TRIP_HI(TRIP_HI), .TRIP_LO(TRIP_LO)) u_therm (
    .clk(clk), .rst_n(rst_n), .die_temp(die_temp), .shutdown(thermal_sd)
  );

  // Anything other than a clean driven-high enable counts as disabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) force_q <= 1'b1;
    else        force_q <= uvlo_active || (enable_code != EN_DRIVEN_HIGH);
  end

  assign tgt = (force_q || thermal_sd) ? TGT_OFF : cmd;

  hbd_deadtime_seq #(.DEAD_CYC(DEAD_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .tgt(tgt),
    .hs_off_fb(hs_off_fb), .ls_off_fb(ls_off_fb),
    .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  assert_disable_forces_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_code != EN_DRIVEN_HIGH) |-> ##2 (!hs_gate && !ls_gate));

  assert_uvlo_forces_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_active |-> ##2 (!hs_gate && !ls_gate));

  assert_thermal_forces_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    thermal_sd |=> (!hs_gate && !ls_gate));

  assert_tristate_forces_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == TGT_OFF) |=> (!hs_gate && !ls_gate));
endmodule

// File: tb/hbd_gate_sequencer_tb_top.sv
`timescale 1ns/1ps
module hbd_gate_sequencer_tb_top;
  localparam int HOLD = 6;
  localparam int DEAD = 3;
  localparam int ON_LAT = DEAD + 2;

  typedef struct {
    int    due;
    bit    hs;
    bit    ls;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pwm_code = 2'b00;
  logic [1:0] enable_code = 2'b01;
  logic       uvlo_active = 1'b0;
  logic [7:0] die_temp = 8'd25;
  logic       hs_stall = 1'b0, ls_stall = 1'b0;
  logic       hs_off_fb, ls_off_fb, hs_gate, ls_gate;

  int   cyc = 0;
  int   checks = 0, errors = 0, overlap = 0;
  bit   finished = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Gate monitors: report off as soon as the gate is low unless stalled.
  assign hs_off_fb = ~hs_gate & ~hs_stall;
  assign ls_off_fb = ~ls_gate & ~ls_stall;

  hbd_gate_sequencer #(.HOLD_CYC(HOLD), .DEAD_CYC(DEAD)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_code(pwm_code), .enable_code(enable_code),
    .uvlo_active(uvlo_active), .die_temp(die_temp),
    .hs_off_fb(hs_off_fb), .ls_off_fb(ls_off_fb),
    .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  task automatic check_pair(string tag, bit ahs, bit als, bit ehs, bit els);
    checks++;
    if (ahs !== ehs || als !== els) begin
      errors++;
      $display("FAIL %s cycle %0d: actual hs=%0b ls=%0b expected hs=%0b ls=%0b",
               tag, cyc, ahs, als, ehs, els);
    end
  endtask

  // Driver side of the scoreboard: queue a gate pair due k edges from now.
  task automatic expect_gates(int k, bit hs, bit ls, string tag);
    exp_t e;
    e.due = cyc + k; e.hs = hs; e.ls = ls; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pop and compare every item due in this cycle.
  always @(negedge clk) begin
    if (hs_gate && ls_gate) overlap++;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        check_pair(sb[i].tag, hs_gate, ls_gate, sb[i].hs, sb[i].ls);
        sb.delete(i);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    check_pair("R1 reset", hs_gate, ls_gate, 1'b0, 1'b0);
    rst_n = 1'b1;
    expect_gates(ON_LAT - 1, 0, 0, "R1 low side not early");
    expect_gates(ON_LAT,     0, 1, "R1 low side after reset");
    idle(10);

    // R3: low -> high with immediate feedback.
    pwm_code = 2'b01;
    expect_gates(1, 0, 1, "R3 low side held one cycle");
    expect_gates(2, 0, 0, "R3 low side drops");
    expect_gates(ON_LAT - 1, 0, 0, "R3 high side not early");
    expect_gates(ON_LAT,     1, 0, "R3 high side on");
    idle(8);

    // R3 mirror: high -> low.
    pwm_code = 2'b00;
    expect_gates(2, 0, 0, "R3 high side drops");
    expect_gates(ON_LAT - 1, 0, 0, "R3 mirror not early");
    expect_gates(ON_LAT,     0, 1, "R3 mirror low side on");
    idle(8);

    // R4: low-side monitor stuck reporting on.
    ls_stall = 1'b1;
    pwm_code = 2'b01;
    expect_gates(2,  0, 0, "R4 low gate dropped");
    expect_gates(10, 0, 0, "R4 high side waits for feedback");
    idle(12);
    ls_stall = 1'b0;
    expect_gates(DEAD - 1, 0, 0, "R4 delay after feedback not early");
    expect_gates(DEAD,     1, 0, "R4 high side after feedback plus delay");
    idle(6);

    // R6: short mid-window excursion.
    pwm_code = 2'b10;
    for (int k = 1; k <= HOLD - 1; k++) expect_gates(k, 1, 0, "R6 short mid ignored");
    idle(HOLD - 1);
    pwm_code = 2'b01;
    for (int k = 1; k <= 4; k++) expect_gates(k, 1, 0, "R6 gates unchanged after glitch");
    idle(6);

    // R5: qualified tri-state.
    pwm_code = 2'b11;
    expect_gates(HOLD,      1, 0, "R5 not before hold-off");
    expect_gates(HOLD + 1,  0, 0, "R5 both off after hold-off");
    expect_gates(HOLD + 12, 0, 0, "R5 stays off while mid");
    idle(HOLD + 14);

    // R7: exit tri-state to low, then via tri-state to high.
    pwm_code = 2'b00;
    expect_gates(ON_LAT - 1, 0, 0, "R7 low exit not early");
    expect_gates(ON_LAT,     0, 1, "R7 low exit turns low side on");
    idle(8);
    pwm_code = 2'b10;
    idle(HOLD + 4);
    check_pair("R5 off before high exit", hs_gate, ls_gate, 1'b0, 1'b0);
    pwm_code = 2'b01;
    expect_gates(ON_LAT - 1, 0, 0, "R7 high exit not early");
    expect_gates(ON_LAT,     1, 0, "R7 high exit turns high side on");
    idle(8);

    // R11: retarget during pending delay.
    pwm_code = 2'b00;
    expect_gates(2, 0, 0, "R11 high side drops");
    idle(3);
    pwm_code = 2'b01;
    for (int k = 1; k <= ON_LAT - 1; k++) expect_gates(k, 0, 0, "R11 restarted delay");
    expect_gates(ON_LAT, 1, 0, "R11 high side after full restart");
    idle(8);

    // R8: disable driven low, then undriven.
    enable_code = 2'b00;
    expect_gates(1, 1, 0, "R8 before disable lands");
    expect_gates(2, 0, 0, "R8 disabled low");
    expect_gates(8, 0, 0, "R8 stays disabled");
    idle(9);
    enable_code = 2'b01;
    expect_gates(ON_LAT, 1, 0, "R8 re-enable resequences");
    idle(8);
    enable_code = 2'b10;
    expect_gates(2, 0, 0, "R8 undriven disables");
    idle(5);
    enable_code = 2'b01;
    idle(8);

    // R9: lockout ignores PWM.
    uvlo_active = 1'b1;
    expect_gates(2, 0, 0, "R9 lockout off");
    idle(3);
    pwm_code = 2'b00;
    for (int k = 1; k <= 8; k++) expect_gates(k, 0, 0, "R9 PWM ignored");
    idle(8);
    uvlo_active = 1'b0;
    expect_gates(ON_LAT - 1, 0, 0, "R9 release not early");
    expect_gates(ON_LAT,     0, 1, "R9 release low side on");
    idle(8);

    // R10: thermal hysteresis.
    die_temp = 8'd180;
    expect_gates(5, 0, 1, "R10 at threshold no trip");
    idle(6);
    die_temp = 8'd181;
    expect_gates(2, 0, 0, "R10 trip above 180");
    idle(3);
    die_temp = 8'd170;
    expect_gates(5,  0, 0, "R10 held between thresholds");
    expect_gates(10, 0, 0, "R10 still held");
    idle(11);
    die_temp = 8'd155;
    expect_gates(6, 0, 0, "R10 not released at 155");
    idle(7);
    die_temp = 8'd154;
    expect_gates(ON_LAT - 1, 0, 0, "R10 release not early");
    expect_gates(ON_LAT,     0, 1, "R10 released below 155");
    idle(8);

    checks++;
    if (overlap != 0) begin
      errors++;
      $display("FAIL R2 overlap cycles: actual %0d expected 0", overlap);
    end
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard pending: actual %0d expected 0", sb.size());
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule